// File: doc/BRIEF.md
# Slot Interrupt Router with Latched Non-Maskable Group

The router collects interrupt requests from eight peripheral slots and presents them to a processor as five interrupt inputs. Slots 0 to 3 form the direct group. Each of them drives one maskable interrupt line, and that line follows the slot's request level with no memory of past events. Slots 4 to 7 form the latched group. After synchronization, a rising request in any of these slots sets a sticky flag for that slot. The four flags are ORed together onto a single non-maskable interrupt line.

Each sticky flag is cleared on its own by a software write. The write goes to one dedicated control address, and data bit k names slot k. A flag that is pending in one slot survives a clear aimed at another slot. When a clear and a fresh rising request on the same slot arrive in the same cycle, the flag stays set, so no event is lost.

The block also decodes the processor address into the eight 32-byte slot windows. It outputs a one-hot slot select, a hit flag and the 5-bit offset inside the window.

Top module: `slot_irq_router`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `int_direct` is 0000 and `nmi` is 0.
- R2: `int_direct[k]` for k = 0..3 equals `slot_req[k]` delayed by two clock edges, for both the rising and the falling change. It does not hold a past request.
- R3: A 0-to-1 change of `slot_req[k]` for k = 4..7 sets that slot's flag, so `nmi` is 1 after the third clock edge. The flag stays set after the request returns to 0.
- R4: A 1-to-0 change of a latched-group request, or a request held at 1 after its flag was cleared, never sets a flag.
- R5: A cycle with `wr_en` = 1, `addr` = 0x1C0 and `wr_data[k]` = 1 (k = 4..7) clears flag k at the next edge and leaves the other flags as they were. Bits 0..3 of `wr_data` have no effect.
- R6: If a clear for slot k and a newly detected rising request of slot k fall in the same cycle, flag k stays set.
- R7: A write to any address other than 0x1C0 clears no flag, and a cycle with `wr_en` = 0 clears no flag.
- R8: The slot windows start at 0x080, 0x0A0, 0x0C0 and 0x0E0 for slots 0..3, and at 0x140, 0x160, 0x180 and 0x1A0 for slots 4..7. Each window is 32 bytes long. An address inside window k gives `slot_sel` with only bit k set, `addr_hit` = 1 and `slot_ofs` = addr[4:0]. The decode is combinational.
- R9: An address outside every window (for example 0x07F, 0x100, 0x13F, 0x1C0) gives `slot_sel` = 0 and `addr_hit` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_req | input | 8 | Asynchronous interrupt request level per slot |
| addr | input | 10 | Processor address for window decode and clear write |
| wr_en | input | 1 | Write strobe for the cycle |
| wr_data | input | 8 | Write data; bits 4..7 select the flags to clear |
| int_direct | output | 4 | Maskable interrupt lines for slots 0..3 |
| nmi | output | 1 | OR of the four latched-group flags |
| slot_sel | output | 8 | One-hot slot window select |
| slot_ofs | output | 5 | Byte offset inside the selected window |
| addr_hit | output | 1 | Address lies inside some slot window |

## Verification
A direct line answers two edges after a request change, because it passes through two synchronizer stages. The non-maskable line answers three edges after a rising request: two synchronizer stages, then the flag register fed by the edge detector. A clear takes effect one edge after the write cycle, and the decode results hold as soon as the address settles. The bench drives and samples on falling edges, counts exactly that many rising edges before each check, and also confirms the output is still inactive one edge earlier. The same-cycle case puts the clear write in the cycle that follows the second synchronizer edge, which is exactly where the detected rising request sits.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  localparam int WIN_BYTES = 32;
  localparam int LOW_BASE  = 'h080;
  localparam int HIGH_BASE = 'h140;

  // start address of slot k's window; the direct group and the latched group
  // each occupy a contiguous run of windows
  function automatic int slot_base(input int k, input int n_direct);
    if (k < n_direct) return LOW_BASE + WIN_BYTES * k;
    else              return HIGH_BASE + WIN_BYTES * (k - n_direct);
  endfunction
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nmi_latch_bank.sv
module nmi_latch_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_s,
  input  logic [N-1:0] clr,
  output logic         nmi
);
  logic [N-1:0] prev;
  logic [N-1:0] flag;
  logic [N-1:0] rise_evt;

  assign rise_evt = req_s & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      flag <= '0;
    end else begin
      prev <= req_s;
      // a new edge wins over a clear in the same cycle
      flag <= rise_evt | (flag & ~clr);
    end
  end

  assign nmi = |flag;

  AST_NMI_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi) |-> $past(|clr)); // R7

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_chk
      AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt[k] |=> flag[k]); // R3
      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[k] && !rise_evt[k]) |=> !flag[k]); // R5
      AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[k] && !clr[k]) |=> flag[k]); // R5
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag[k] && !rise_evt[k]) |=> !flag[k]); // R4
    end
  endgenerate
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder
  import slot_irq_pkg::*;
#(
  parameter int N_SLOTS  = 8,
  parameter int N_DIRECT = 4,
  parameter int ADDR_W   = 10,
  parameter int OFS_W    = $clog2(WIN_BYTES)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_SLOTS-1:0] sel,
  output logic [OFS_W-1:0]   ofs,
  output logic               hit
);
  genvar k;
  generate
    for (k = 0; k < N_SLOTS; k++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(slot_base(k, N_DIRECT));
      assign sel[k] = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
    end
  endgenerate

  assign ofs = addr[OFS_W-1:0];
  assign hit = |sel;

  always_comb begin
    if (!$isunknown(addr)) begin
      AST_SEL_ONEHOT: assert ($onehot0(sel)); // R8
    end
  end
endmodule

// File: rtl/slot_irq_router.sv
module slot_irq_router
  import slot_irq_pkg::*;
#(
  parameter int                N_SLOTS     = 8,
  parameter int                N_DIRECT    = 4,
  parameter int                ADDR_W      = 10,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CLR_ADDR    = 10'h1C0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SLOTS-1:0]  slot_req,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [N_SLOTS-1:0]  wr_data,
  output logic [N_DIRECT-1:0] int_direct,
  output logic                nmi,
  output logic [N_SLOTS-1:0]  slot_sel,
  output logic [4:0]          slot_ofs,
  output logic                addr_hit
);
  localparam int N_LATCH = N_SLOTS - N_DIRECT;
  localparam int OFS_W   = $clog2(WIN_BYTES);

  logic [N_SLOTS-1:0] req_s;
  logic               clr_write;
  logic [N_LATCH-1:0] clr_vec;
  logic               unused_low_data;

  req_sync #(.W(N_SLOTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(slot_req), .q(req_s)
  );

  assign int_direct = req_s[N_DIRECT-1:0];

  // control write: data bit k addresses latched slot k
  assign clr_write       = wr_en && (addr == CLR_ADDR);
  assign clr_vec         = clr_write ? wr_data[N_SLOTS-1:N_DIRECT] : '0;
  assign unused_low_data = ^wr_data[N_DIRECT-1:0];

  nmi_latch_bank #(.N(N_LATCH)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_s(req_s[N_SLOTS-1:N_DIRECT]),
    .clr(clr_vec), .nmi(nmi)
  );

  slot_decoder #(.N_SLOTS(N_SLOTS), .N_DIRECT(N_DIRECT), .ADDR_W(ADDR_W),
                 .OFS_W(OFS_W)) u_dec (
    .addr(addr), .sel(slot_sel), .ofs(slot_ofs), .hit(addr_hit)
  );

  genvar k;
  generate
    for (k = 0; k < N_DIRECT; k++) begin : g_dchk
      AST_DIRECT_RISE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_direct[k]) |-> $past(slot_req[k], 2)); // R2
      AST_DIRECT_FALL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_direct[k]) |-> !$past(slot_req[k], 2)); // R2
    end
  endgenerate
endmodule

// File: tb/slot_irq_router_bench.sv
module slot_irq_router_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] slot_req = '0;
  logic [9:0] addr = '0;
  logic       wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [3:0] int_direct;
  logic       nmi;
  logic [7:0] slot_sel;
  logic [4:0] slot_ofs;
  logic       addr_hit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  slot_irq_router u_slot_irq_router (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .int_direct(int_direct), .nmi(nmi),
    .slot_sel(slot_sel), .slot_ofs(slot_ofs), .addr_hit(addr_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic nedges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_write(input logic [9:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    nedges(1);
    wr_en = 0; wr_data = '0; addr = '0;
  endtask

  task automatic t_reset;
    slot_req = 8'hFF;
    nedges(3);
    chk("R1 int_direct in reset", int_direct, 4'h0);
    chk("R1 nmi in reset", nmi, 0);
    rst_n = 1;
    nedges(1);
    chk("R1 int_direct first cycle", int_direct, 4'h0);
    chk("R1 nmi first cycle", nmi, 0);
    slot_req = '0;
    nedges(4);
    // the latched flags were set by the request held across reset release
    clear_write(10'h1C0, 8'hF0);
    chk("R5 all cleared after reset test", nmi, 0);
  endtask

  task automatic t_direct;
    slot_req = 8'h05;
    nedges(1);
    chk("R2 no change after one edge", int_direct, 4'h0);
    nedges(1);
    chk("R2 rise after two edges", int_direct, 4'h5);
    chk("R2 direct group does not touch nmi", nmi, 0);
    slot_req = 8'h0A;
    nedges(1);
    chk("R2 old value one edge later", int_direct, 4'h5);
    nedges(1);
    chk("R2 follows new pattern", int_direct, 4'hA);
    slot_req = 8'h00;
    nedges(2);
    chk("R2 no latching on direct lines", int_direct, 4'h0);
  endtask

  task automatic t_latch_set;
    slot_req = 8'h10;
    nedges(2);
    chk("R3 nmi not yet after two edges", nmi, 0);
    nedges(1);
    chk("R3 nmi after three edges", nmi, 1);
    slot_req = 8'h00;
    nedges(4);
    chk("R3 flag holds after request drops", nmi, 1);
    clear_write(10'h1C0, 8'h10);
    chk("R5 clear drops flag", nmi, 0);
  endtask

  task automatic t_no_false_edges;
    slot_req = 8'h20;
    nedges(4);
    clear_write(10'h1C0, 8'h20);
    nedges(4);
    chk("R4 steady high does not re-set", nmi, 0);
    slot_req = 8'h00;
    nedges(4);
    chk("R4 falling request does not set", nmi, 0);
  endtask

  task automatic t_independent_clear;
    slot_req = 8'h90;
    nedges(4);
    slot_req = 8'h00;
    chk("R3 two slots pending", nmi, 1);
    clear_write(10'h1C0, 8'h1F);
    chk("R5 clearing slot 4 keeps slot 7 pending", nmi, 1);
    clear_write(10'h1C0, 8'h0F);
    chk("R5 low data bits have no effect", nmi, 1);
    clear_write(10'h1C1, 8'hF0);
    chk("R7 other address clears nothing", nmi, 1);
    addr = 10'h1C0; wr_data = 8'hF0; wr_en = 0;
    nedges(1);
    addr = '0; wr_data = '0;
    chk("R7 no strobe clears nothing", nmi, 1);
    clear_write(10'h1C0, 8'h80);
    chk("R5 clearing slot 7 drops nmi", nmi, 0);
  endtask

  task automatic t_same_cycle;
    slot_req = 8'h40;
    nedges(4);
    slot_req = 8'h00;
    nedges(3);
    chk("R3 slot 6 pending before collision", nmi, 1);
    slot_req = 8'h40;
    nedges(2);
    // the detected rise occupies this cycle; clear it at the same time
    clear_write(10'h1C0, 8'h40);
    chk("R6 new edge wins over clear", nmi, 1);
    nedges(1);
    chk("R6 flag still set next cycle", nmi, 1);
    clear_write(10'h1C0, 8'h40);
    chk("R6 later clear drops flag", nmi, 0);
    slot_req = 8'h00;
    nedges(3);
  endtask

  task automatic t_decode;
    for (int k = 0; k < 8; k++) begin
      int base = (k < 4) ? ('h80 + 32*k) : ('h140 + 32*(k-4));
      addr = 10'(base + 5 + 3*k);
      #1;
      chk($sformatf("R8 select slot %0d", k), slot_sel, 32'(1) << k);
      chk($sformatf("R8 offset slot %0d", k), slot_ofs, 5 + 3*k);
      chk($sformatf("R8 hit slot %0d", k), addr_hit, 1);
      addr = 10'(base + 31);
      #1;
      chk($sformatf("R8 last byte slot %0d", k), slot_sel, 32'(1) << k);
    end
    addr = 10'h07F; #1;
    chk("R9 below first window", {addr_hit, slot_sel}, 9'h0);
    addr = 10'h100; #1;
    chk("R9 gap 0x100", {addr_hit, slot_sel}, 9'h0);
    addr = 10'h13F; #1;
    chk("R9 gap 0x13F", {addr_hit, slot_sel}, 9'h0);
    addr = 10'h1C0; #1;
    chk("R9 control address is outside", {addr_hit, slot_sel}, 9'h0);
    addr = '0;
    nedges(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_direct();
    t_latch_set();
    t_no_false_edges();
    t_independent_clear();
    t_same_cycle();
    t_decode();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule